// File: doc/BRIEF.md
# Per-PC Load Locality Profiler

The profiler watches a stream of records describing critical loads. Each record names the program counter of a load, the data address it accessed and the dynamic instruction count at which it ran. A small direct-mapped table, indexed by the low bits of the PC and holding the full PC as a tag, remembers the previous address and instruction count for each tracked load. When a load recurs, the block measures how far its address moved (as an absolute value) and how many instructions passed since its last run. It then adds both measures to saturating sums and bumps a sample counter, so software can form the averages by division.

Each repeat occurrence is also binned. An unchanged address is a same-location hit. An address jump larger than 512 is a far-address hit. An instruction distance larger than 512 marks low temporal reuse. A record whose PC maps onto an entry held by a different PC evicts that entry and starts it afresh. The statistics are read through a registered read port that takes an entry index and a field selector.

Top module: `locality_profiler`

## Requirements
- R1: The first record of a PC in an entry (empty entry or tag miss) only stores its address and count: the sample count, both sums and all three category counters read 0 afterwards.
- R2: Each later record of the same PC adds the absolute difference between its address and the stored address to the address sum and raises the sample count by one.
- R3: Each later record adds its instruction count minus the stored instruction count (modulo 2^DIC_W) to the gap sum.
- R4: A later record whose address equals the stored address raises the same-location counter.
- R5: A later record whose absolute address difference is greater than 512 raises the far-address counter; a difference of exactly 512 does not.
- R6: A later record whose instruction gap is greater than 512 raises the far-gap counter; a gap of exactly 512 does not.
- R7: The entry is chosen by PC bits [IDX_W-1:0]; a record whose PC differs from the stored tag replaces the tag and clears every statistic of that entry.
- R8: The address and gap sums stop at all ones instead of wrapping.
- R9: While reset is low rec_ready is 0 and every entry is invalid; rec_ready is 1 from the first clock edge after reset is released.
- R10: rd_data returns, one clock after rd_idx and rd_sel are presented, the field chosen by rd_sel: 0 stored PC, 1 sample count, 2 address sum, 3 gap sum, 4 same-location count, 5 far-address count, 6 far-gap count, 7 entry valid in bit 0; narrower fields are zero-extended.
- R11: A cycle in which rec_valid is low changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rec_valid | input | 1 | A load record is offered |
| rec_ready | output | 1 | The profiler accepts a record this cycle |
| rec_pc | input | PC_W | PC of the load |
| rec_addr | input | ADDR_W | Data address of the load |
| rec_dic | input | DIC_W | Dynamic instruction count of the load |
| rd_idx | input | $clog2(ENTRIES) | Table entry to read |
| rd_sel | input | 3 | Field selector (see R10) |
| rd_data | output | RD_W | Selected field, registered |

## Verification
A stale or corrupted last-address or last-count field stays invisible until the same PC returns, and then shows up at once as a wrong address or gap sum in the very next read, so the bench reads every field after each record instead of only at the end. A wrong threshold comparison shows only when a difference sits exactly at or just over 512, which is why the directed cases place deltas of 512 and 513. A tag that fails to reset its statistics shows on the first read after an evicting record, as a nonzero sample count.

// File: rtl/lp_pkg.sv
// Shared definitions for the load locality profiler.
// Assumes: the read port selector is three bits wide.
package lp_pkg;

    // Read-port field selector codes.
    typedef enum logic [2:0] {
        F_TAG      = 3'd0,
        F_SAMPLES  = 3'd1,
        F_ADDR_SUM = 3'd2,
        F_GAP_SUM  = 3'd3,
        F_SAME     = 3'd4,
        F_FAR_ADDR = 3'd5,
        F_FAR_GAP  = 3'd6,
        F_VALID    = 3'd7
    } field_e;

    // Default distance above which an occurrence counts as far.
    localparam int unsigned FAR_LIMIT_DEF = 512;

    // Number of per-entry event counters (samples, same, far addr, far gap).
    localparam int unsigned NUM_CNT = 4;

endpackage

// File: rtl/lp_delta.sv
// Computes the locality measures of one occurrence against the stored
// history of its PC: absolute address distance, instruction gap and the
// three category flags.
// Assumes: instruction counts increase; the gap is taken modulo 2^DIC_W.
module lp_delta #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DIC_W  = 32,
    parameter int unsigned LIMIT  = 512
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DIC_W-1:0]  cur_dic,
    input  logic [DIC_W-1:0]  last_dic,
    output logic [ADDR_W-1:0] abs_diff,
    output logic [DIC_W-1:0]  gap,
    output logic              is_same,
    output logic              is_far_addr,
    output logic              is_far_gap
);

    localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(LIMIT);
    localparam logic [DIC_W-1:0]  GAP_LIMIT  = DIC_W'(LIMIT);

    // Distance measures and category flags.
    always_comb begin
        abs_diff    = (cur_addr >= last_addr) ? (cur_addr - last_addr)
                                              : (last_addr - cur_addr);
        gap         = cur_dic - last_dic;
        is_same     = (cur_addr == last_addr);
        is_far_addr = (abs_diff > ADDR_LIMIT);
        is_far_gap  = (gap > GAP_LIMIT);
    end

    // Same-location and far-address bins never overlap.
    always_comb begin
        a_r5_bins_disjoint: assert (!(is_same && is_far_addr))
            else $error("same and far address flagged together");
    end

endmodule

// File: rtl/lp_sat_add.sv
// Saturating adder: y = a + b, clamped to all ones on overflow.
// Assumes: IW <= W, b is unsigned and zero-extended.
module lp_sat_add #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 32
) (
    input  logic [W-1:0]  a,
    input  logic [IW-1:0] b,
    output logic [W-1:0]  y
);

    logic [W:0] wide;

    // Add with one carry bit and clamp when it is set.
    always_comb begin
        wide = {1'b0, a} + (W+1)'(b);
        y    = wide[W] ? {W{1'b1}} : wide[W-1:0];
    end

endmodule

// File: rtl/lp_table.sv
// Direct-mapped history and statistics table. One record can be folded in
// per cycle; a registered read port returns one field of one entry.
// Assumes: ENTRIES is a power of two >= 2; ADDR_W and DIC_W <= SUM_W;
// RD_W covers PC_W, SUM_W and CNT_W.
module lp_table
    import lp_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DIC_W   = 32,
    parameter int unsigned SUM_W   = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned LIMIT   = 512,
    parameter int unsigned RD_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd_en,
    input  logic [PC_W-1:0]            upd_pc,
    input  logic [ADDR_W-1:0]          upd_addr,
    input  logic [DIC_W-1:0]           upd_dic,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    input  logic [2:0]                 rd_sel,
    output logic [RD_W-1:0]            rd_data
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic              valid_q [ENTRIES];
    logic [PC_W-1:0]   tag_q   [ENTRIES];
    logic [ADDR_W-1:0] laddr_q [ENTRIES];
    logic [DIC_W-1:0]  ldic_q  [ENTRIES];
    logic [SUM_W-1:0]  asum_q  [ENTRIES];
    logic [SUM_W-1:0]  gsum_q  [ENTRIES];
    logic [CNT_W-1:0]  cnt_q   [NUM_CNT][ENTRIES];

    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic [ADDR_W-1:0] abs_diff;
    logic [DIC_W-1:0]  gap;
    logic              is_same, is_far_addr, is_far_gap;
    logic [SUM_W-1:0]  asum_nx, gsum_nx;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]  cnt_nx [NUM_CNT];

    // Entry selection and tag compare for the incoming record.
    always_comb begin
        idx = upd_pc[IDX_W-1:0];
        hit = valid_q[idx] && (tag_q[idx] == upd_pc);
    end

    lp_delta #(
        .ADDR_W (ADDR_W),
        .DIC_W  (DIC_W),
        .LIMIT  (LIMIT)
    ) u_delta (
        .cur_addr    (upd_addr),
        .last_addr   (laddr_q[idx]),
        .cur_dic     (upd_dic),
        .last_dic    (ldic_q[idx]),
        .abs_diff    (abs_diff),
        .gap         (gap),
        .is_same     (is_same),
        .is_far_addr (is_far_addr),
        .is_far_gap  (is_far_gap)
    );

    lp_sat_add #(.W(SUM_W), .IW(ADDR_W)) u_asum (
        .a (asum_q[idx]), .b (abs_diff), .y (asum_nx)
    );

    lp_sat_add #(.W(SUM_W), .IW(DIC_W)) u_gsum (
        .a (gsum_q[idx]), .b (gap), .y (gsum_nx)
    );

    // Increment bits for the counter bank, in field order.
    always_comb begin
        cnt_inc = {is_far_gap, is_far_addr, is_same, 1'b1};
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        lp_sat_add #(.W(CNT_W), .IW(1)) u_cnt (
            .a (cnt_q[k][idx]), .b (cnt_inc[k]), .y (cnt_nx[k])
        );
    end

    // Table state: clear on reset, fold in or allocate on an accepted record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                laddr_q[i] <= '0;
                ldic_q[i]  <= '0;
                asum_q[i]  <= '0;
                gsum_q[i]  <= '0;
                for (int k = 0; k < NUM_CNT; k++) cnt_q[k][i] <= '0;
            end
        end else if (upd_en) begin
            laddr_q[idx] <= upd_addr;
            ldic_q[idx]  <= upd_dic;
            if (hit) begin
                asum_q[idx] <= asum_nx;
                gsum_q[idx] <= gsum_nx;
                for (int k = 0; k < NUM_CNT; k++) cnt_q[k][idx] <= cnt_nx[k];
            end else begin
                valid_q[idx] <= 1'b1;
                tag_q[idx]   <= upd_pc;
                asum_q[idx]  <= '0;
                gsum_q[idx]  <= '0;
                for (int k = 0; k < NUM_CNT; k++) cnt_q[k][idx] <= '0;
            end
        end
    end

    // Registered read port: select one field of one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            case (field_e'(rd_sel))
                F_TAG:      rd_data <= RD_W'(tag_q[rd_idx]);
                F_SAMPLES:  rd_data <= RD_W'(cnt_q[0][rd_idx]);
                F_ADDR_SUM: rd_data <= RD_W'(asum_q[rd_idx]);
                F_GAP_SUM:  rd_data <= RD_W'(gsum_q[rd_idx]);
                F_SAME:     rd_data <= RD_W'(cnt_q[1][rd_idx]);
                F_FAR_ADDR: rd_data <= RD_W'(cnt_q[2][rd_idx]);
                F_FAR_GAP:  rd_data <= RD_W'(cnt_q[3][rd_idx]);
                default:    rd_data <= RD_W'(valid_q[rd_idx]);
            endcase
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        // R1: an allocation leaves a valid entry with no samples or sums.
        a_r1_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && !hit && idx == IDX_W'(i)) |=>
            (valid_q[i] && cnt_q[0][i] == '0 && asum_q[i] == '0 && gsum_q[i] == '0));
        // R8: folding a record in never makes a sum smaller.
        a_r8_sum_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && hit && idx == IDX_W'(i)) |=>
            (asum_q[i] >= $past(asum_q[i]) && gsum_q[i] >= $past(gsum_q[i])));
        // R11: without an accepted record an entry holds still.
        a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd_en && $past(rst_n)) |=>
            ($stable(tag_q[i]) && $stable(cnt_q[0][i]) && $stable(asum_q[i])));
        // R7: after an update the entry carries the record's PC.
        a_r7_tag_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && idx == IDX_W'(i)) |=> (tag_q[i] == $past(upd_pc)));
    end

endmodule

// File: rtl/locality_profiler.sv
// Top of the per-PC load locality profiler. Accepts one load record per
// cycle once out of reset and exposes per-entry statistics through a
// registered read port.
// Assumes: synchronous active-low reset; software divides sums by samples.
module locality_profiler #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DIC_W   = 32,
    parameter int unsigned SUM_W   = 32,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned LIMIT   = lp_pkg::FAR_LIMIT_DEF,
    parameter int unsigned RD_W    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rec_valid,
    output logic                       rec_ready,
    input  logic [PC_W-1:0]            rec_pc,
    input  logic [ADDR_W-1:0]          rec_addr,
    input  logic [DIC_W-1:0]           rec_dic,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    input  logic [2:0]                 rd_sel,
    output logic [RD_W-1:0]            rd_data
);

    logic ready_q;
    logic upd_en;

    // Ready rises on the first edge after reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Record acceptance.
    always_comb begin
        rec_ready = ready_q;
        upd_en    = rec_valid && ready_q;
    end

    lp_table #(
        .PC_W    (PC_W),
        .ADDR_W  (ADDR_W),
        .DIC_W   (DIC_W),
        .SUM_W   (SUM_W),
        .CNT_W   (CNT_W),
        .ENTRIES (ENTRIES),
        .LIMIT   (LIMIT),
        .RD_W    (RD_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .upd_pc   (rec_pc),
        .upd_addr (rec_addr),
        .upd_dic  (rec_dic),
        .rd_idx   (rd_idx),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data)
    );

    // R9: one cycle out of reset the profiler is ready.
    a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rec_ready);

endmodule

// File: tb/locality_profiler_test.sv
module locality_profiler_test;

    localparam int PERIOD = 10;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] addr;
        logic [31:0] dic;
        logic [31:0] samples;
        logic [31:0] asum;
        logic [31:0] gsum;
    } vec_t;

    // Records and the expected statistics of their entry after each one.
    localparam vec_t VECS [8] = '{
        '{32'h11, 32'h1000, 32'd100,  32'd0, 32'd0,    32'd0},   // R1 first
        '{32'h11, 32'h1000, 32'd700,  32'd1, 32'd0,    32'd600}, // R2 R3
        '{32'h11, 32'h1400, 32'd750,  32'd2, 32'd1024, 32'd650},
        '{32'h11, 32'h1200, 32'd760,  32'd3, 32'd1536, 32'd660}, // abs diff
        '{32'h22, 32'h50,   32'd800,  32'd0, 32'd0,    32'd0},
        '{32'h22, 32'h48,   32'd1313, 32'd1, 32'd8,    32'd513},
        '{32'h19, 32'h9000, 32'd1400, 32'd0, 32'd0,    32'd0},   // R7 evict
        '{32'h19, 32'h9001, 32'd1401, 32'd1, 32'd1,    32'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic        rec_ready;
    logic [31:0] rec_pc = '0, rec_addr = '0, rec_dic = '0;
    logic [2:0]  rd_idx = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    locality_profiler uut (
        .clk (clk), .rst_n (rst_n),
        .rec_valid (rec_valid), .rec_ready (rec_ready),
        .rec_pc (rec_pc), .rec_addr (rec_addr), .rec_dic (rec_dic),
        .rd_idx (rd_idx), .rd_sel (rd_sel), .rd_data (rd_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] pc, input logic [31:0] addr, input logic [31:0] dic);
        rec_pc = pc; rec_addr = addr; rec_dic = dic; rec_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    task automatic rd(input int idx, input int sel, output logic [31:0] v);
        rd_idx = 3'(idx); rd_sel = 3'(sel);
        @(negedge clk);
        v = rd_data;
    endtask

    initial begin
        logic [31:0] v;
        @(negedge clk);
        check("R9 ready in reset", {31'd0, rec_ready}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", {31'd0, rec_ready}, 32'd1);
        for (int e = 0; e < 8; e++) begin
            rd(e, 7, v);
            check("R9 entry invalid", v, 32'd0);
        end

        // Vector table walk.
        for (int n = 0; n < 8; n++) begin
            push(VECS[n].pc, VECS[n].addr, VECS[n].dic);
            rd(int'(VECS[n].pc[2:0]), 1, v);
            check("R1/R2/R7 samples", v, VECS[n].samples);
            rd(int'(VECS[n].pc[2:0]), 2, v);
            check("R2 address sum", v, VECS[n].asum);
            rd(int'(VECS[n].pc[2:0]), 3, v);
            check("R3 gap sum", v, VECS[n].gsum);
        end

        // R10: tag and valid fields.
        rd(1, 0, v);  check("R10 R7 tag replaced", v, 32'h19);
        rd(1, 7, v);  check("R10 valid", v, 32'd1);
        rd(5, 7, v);  check("R10 unused entry invalid", v, 32'd0);
        rd(2, 6, v);  check("R6 far gap 513", v, 32'd1);
        rd(2, 4, v);  check("R4 no same", v, 32'd0);

        // Category boundaries on entry 3.
        push(32'h13, 32'd0,   32'd0);
        push(32'h13, 32'd0,   32'd513);
        push(32'h13, 32'd513, 32'd1025);
        push(32'h13, 32'd1,   32'd1026);
        rd(3, 4, v);  check("R4 same location", v, 32'd1);
        rd(3, 5, v);  check("R5 far addr only 513", v, 32'd1);
        rd(3, 6, v);  check("R6 far gap only 513", v, 32'd1);
        rd(3, 1, v);  check("R2 samples", v, 32'd3);
        rd(3, 2, v);  check("R2 abs sum", v, 32'd1025);
        rd(3, 3, v);  check("R3 gap sum", v, 32'd1026);

        // R11: records without rec_valid are ignored.
        rec_pc = 32'h0B; rec_addr = 32'hABC; rec_dic = 32'd9999;
        repeat (3) @(negedge clk);
        rd(3, 0, v);  check("R11 tag kept", v, 32'h13);
        rd(3, 1, v);  check("R11 samples kept", v, 32'd3);
        rd(3, 2, v);  check("R11 sum kept", v, 32'd1025);

        // R8: saturation of the address sum.
        push(32'h14, 32'h0,        32'd0);
        push(32'h14, 32'hFFFFFFFF, 32'd1);
        push(32'h14, 32'h0,        32'd2);
        rd(4, 2, v);  check("R8 address sum saturates", v, 32'hFFFFFFFF);
        rd(4, 3, v);  check("R8 gap sum", v, 32'd2);
        rd(4, 1, v);  check("R8 samples", v, 32'd2);

        // R9: reset again clears the table.
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 ready drops", {31'd0, rec_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3, 7, v);  check("R9 entry cleared", v, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule